// File: doc/BRIEF.md
# Fuse Array Byte Read Port

This block sits between a simple register bus and a one-time-programmable fuse array and lets software read the array one byte at a time. Software owns a single control word. That word carries the macro pin levels as individual bits: chip select (active low), strobe, load and program enable (active low). It also carries a 10-bit byte address. The block decodes these bits straight onto the macro pins. When software raises the strobe during an open read session, the block captures the addressed byte into a data-out register. Software then samples that register.

A read session opens when software writes load and program enable with chip select low. For each byte, software writes the address, sets the strobe, reads data-out and then clears the strobe. Writing 0x9 parks the macro in standby. The project includes a behavioural read-only array model of 1024 bytes. At reset, the model is filled from a pattern fixed by parameters.

Top module: `fuse_rdport`

## Requirements
- R1: The control word is at bus offset 0x0. All 32 bits read back exactly as last written. Its reset value is 0x0000_0009.
- R2: The control word drives the macro pins as follows: bit 0 drives `macro_sel_n`, bit 1 drives `macro_strobe`, bit 2 drives `macro_load`, bit 3 drives `macro_pgm_n`, and bits 15:6 drive `macro_addr`.
- R3: A rising strobe while chip select is low and load is high captures the byte at `macro_addr`. A read of offset 0x4 issued two or more cycles after the control write returns that byte in bits 7:0, with bits 31:8 zero.
- R4: Data-out holds its captured byte until the next capturing strobe rise. Clearing the strobe does not change it. Changing the address without a new rise does not change it either.
- R5: Data-out reads zero while chip select is high or load is low. Raising chip select also discards the held byte, so a later session reads zero until its first strobe rise.
- R6: The array byte at address a is ((a[7:0]*PAT_MUL + PAT_ADD) mod 256) XOR a[9:8]. The defaults are PAT_MUL=37 and PAT_ADD=0x5A.
- R7: Writes to offset 0x4 or to any offset other than 0x0 change nothing. Reads of offsets other than 0x0 and 0x4 return zero.
- R8: `bus_ready` is high in the cycle after each accepted read or write request. It stays low when no request is made. `bus_rdata` is valid while `bus_ready` is high.
- R9: Control bits 4, 5 and 31:16 have no effect on the pins or on the data captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | BUS_AW | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion pulse |
| macro_sel_n | output | 1 | Fuse macro chip select, active low |
| macro_strobe | output | 1 | Fuse macro strobe |
| macro_load | output | 1 | Fuse macro load |
| macro_pgm_n | output | 1 | Fuse macro program enable, active low |
| macro_addr | output | 10 | Fuse macro byte address |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never asserted together. They also assume that software issues a data-out read no sooner than two cycles after the strobe-raising write. Within that assumption, the hold and clear properties check data-out across cycles that have no strobe rise. The stimulus keeps to these assumptions in two ways. Each bus task issues exactly one request at a time. Two idle cycles always follow a strobe rise before data-out is sampled. The bench predicts every byte from the array formula and compares the results through a scoreboard queue as ready pulses arrive.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int FUSE_AW   = 10;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int CTRL_OFS  = 0;
  localparam int DOUT_OFS  = 4;
  localparam int BIT_SELN  = 0;
  localparam int BIT_STRB  = 1;
  localparam int BIT_LOAD  = 2;
  localparam int BIT_PGMN  = 3;
  localparam int ADDR_LSB  = 6;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0009;

  function automatic logic [BYTE_W-1:0] fuse_pattern(
      input logic [FUSE_AW-1:0] a, input logic [7:0] mul, input logic [7:0] add);
    logic [15:0] prod;
    prod = 16'(a[7:0]) * 16'(mul) + 16'(add);
    return prod[7:0] ^ {6'b0, a[9:8]};
  endfunction
endpackage

// File: rtl/fuse_bus_regs.sv
module fuse_bus_regs
  import fuse_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [BYTE_W-1:0]    dout_view,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_ready,
  output logic                 sel_n,
  output logic                 strobe,
  output logic                 load,
  output logic                 pgm_n,
  output logic [FUSE_AW-1:0]   faddr
);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(CTRL_OFS);
  localparam logic [BUS_AW-1:0] A_DOUT = BUS_AW'(DOUT_OFS);

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ready_q, ready_d;
  logic              ctrl_en, rdata_en;

  always_comb begin
    ctrl_en  = bus_wr && (bus_addr == A_CTRL);
    ctrl_d   = bus_wdata;
    rdata_en = bus_rd;
    if (bus_addr == A_CTRL)      rdata_d = ctrl_q;
    else if (bus_addr == A_DOUT) rdata_d = {{(DATA_W-BYTE_W){1'b0}}, dout_view};
    else                         rdata_d = '0;
    ready_d = bus_wr || bus_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (rdata_en) rdata_q <= rdata_d;
      ready_q <= ready_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_ready = ready_q;
  assign sel_n  = ctrl_q[BIT_SELN];
  assign strobe = ctrl_q[BIT_STRB];
  assign load   = ctrl_q[BIT_LOAD];
  assign pgm_n  = ctrl_q[BIT_PGMN];
  assign faddr  = ctrl_q[ADDR_LSB +: FUSE_AW];

  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> (faddr == $past(bus_wdata[ADDR_LSB +: FUSE_AW])
                                        && sel_n == $past(bus_wdata[BIT_SELN])));
  p_ignored_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != A_CTRL) |=> ($stable(faddr) && $stable(sel_n) && $stable(strobe)));
  p_ready_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ready);
  p_no_spurious_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> !bus_ready);
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
  import fuse_pkg::*;
#(
  parameter logic [7:0] PAT_MUL = 8'd37,
  parameter logic [7:0] PAT_ADD = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sense_en,
  input  logic [FUSE_AW-1:0] addr,
  output logic [BYTE_W-1:0]  sense_q
);
  localparam int DEPTH = 1 << FUSE_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fuse_pattern(FUSE_AW'(i), PAT_MUL, PAT_ADD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sense_q <= '0;
    else if (sense_en) sense_q <= mem[addr];
  end
endmodule

// File: rtl/fuse_capture.sv
module fuse_capture
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              strobe,
  input  logic              load,
  input  logic [BYTE_W-1:0] sense_q,
  output logic              sense_en,
  output logic [BYTE_W-1:0] dout_view
);
  logic              strobe_d;
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] dout_q, dout_d;
  logic              active, rise;

  always_comb begin
    active   = !sel_n && load;
    rise     = strobe && !strobe_d && active;
    sense_en = rise;
    pend_d   = rise;
    dout_d   = dout_q;
    if (sel_n)       dout_d = '0;
    else if (pend_q) dout_d = sense_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      pend_q   <= 1'b0;
      dout_q   <= '0;
    end else begin
      strobe_d <= strobe;
      pend_q   <= pend_d;
      dout_q   <= dout_d;
    end
  end

  assign dout_view = active ? dout_q : '0;

  p_capture_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sel_n) |=> (dout_q == $past(sense_q)));
  p_hold_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !sel_n) |=> $stable(dout_q));
  p_clear_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (dout_q == '0));
  p_zero_view_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !load) |-> (dout_view == '0));
endmodule

// File: rtl/fuse_rdport.sv
module fuse_rdport
  import fuse_pkg::*;
#(
  parameter int         BUS_AW  = 8,
  parameter logic [7:0] PAT_MUL = 8'd37,
  parameter logic [7:0] PAT_ADD = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  output logic               macro_sel_n,
  output logic               macro_strobe,
  output logic               macro_load,
  output logic               macro_pgm_n,
  output logic [9:0]         macro_addr
);
  logic rst_meta_n, rst_sync_n;
  logic sense_en;
  logic [BYTE_W-1:0] sense_q, dout_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fuse_bus_regs #(.BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dout_view(dout_view), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .sel_n(macro_sel_n), .strobe(macro_strobe), .load(macro_load),
    .pgm_n(macro_pgm_n), .faddr(macro_addr)
  );

  fuse_array_model #(.PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD)) u_array (
    .clk(clk), .rst_n(rst_sync_n), .sense_en(sense_en),
    .addr(macro_addr), .sense_q(sense_q)
  );

  fuse_capture u_capture (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_n(macro_sel_n), .strobe(macro_strobe), .load(macro_load),
    .sense_q(sense_q), .sense_en(sense_en), .dout_view(dout_view)
  );
endmodule

// File: tb/fuse_rdport_tb.sv
module fuse_rdport_tb;
  localparam int BUS_AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ready;
  logic macro_sel_n, macro_strobe, macro_load, macro_pgm_n;
  logic [9:0] macro_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { bit is_rd; logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  fuse_rdport #(.BUS_AW(BUS_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .macro_sel_n(macro_sel_n), .macro_strobe(macro_strobe),
    .macro_load(macro_load), .macro_pgm_n(macro_pgm_n), .macro_addr(macro_addr)
  );

  function automatic logic [7:0] pat(input logic [9:0] a);
    logic [15:0] p;
    p = 16'(a[7:0]) * 16'd37 + 16'h5A;
    return p[7:0] ^ {6'b0, a[9:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
    item_t it;
    @(negedge clk);
    it.is_rd = 1'b0; it.exp = '0; it.req = "R8";
    sb.push_back(it);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [BUS_AW-1:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    it.is_rd = 1'b1; it.exp = exp; it.req = req;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_ready) begin
      if (sb.size() == 0) begin
        check("R8 unexpected ready", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_rd) check(it.req, bus_rdata, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] addrs [5];
    logic [31:0] junk;
    addrs[0] = 10'h000; addrs[1] = 10'h001; addrs[2] = 10'h155;
    addrs[3] = 10'h3FF; addrs[4] = 10'h2A0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // reset state
    check("R2 reset sel_n", 32'(macro_sel_n), 32'd1);
    check("R2 reset pgm_n", 32'(macro_pgm_n), 32'd1);
    check("R2 reset strobe/load", {30'd0, macro_strobe, macro_load}, 32'd0);
    check("R8 idle ready low", 32'(bus_ready), 32'd0);
    bus_read(8'h00, 32'h9, "R1 reset ctrl");
    bus_read(8'h04, 32'h0, "R5 standby dout");

    // open session
    bus_write(8'h00, 32'h0000_000C);
    idle(1);
    check("R2 session sel_n", 32'(macro_sel_n), 32'd0);
    check("R2 session load", 32'(macro_load), 32'd1);
    bus_read(8'h04, 32'h0, "R5 no strobe yet");

    foreach (addrs[k]) begin
      logic [31:0] base;
      base = 32'h0000_000C | (32'(addrs[k]) << 6);
      bus_write(8'h00, base);
      bus_write(8'h00, base | 32'h2);
      idle(1);
      check("R2 macro_addr", 32'(macro_addr), 32'(addrs[k]));
      check("R2 strobe pin", 32'(macro_strobe), 32'd1);
      bus_read(8'h04, {24'd0, pat(addrs[k])}, "R3 R6 captured byte");
      bus_write(8'h00, base);
      bus_read(8'h04, {24'd0, pat(addrs[k])}, "R4 hold after strobe low");
      bus_write(8'h00, 32'h0000_000C | (32'(addrs[k] ^ 10'h1) << 6));
      bus_read(8'h04, {24'd0, pat(addrs[k])}, "R4 hold after address change");
    end

    // undefined bits
    junk = 32'hABCD_0030 | 32'h0000_000C | (32'h0CC << 6);
    bus_write(8'h00, junk);
    bus_read(8'h00, junk, "R1 readback all bits");
    bus_write(8'h00, junk | 32'h2);
    idle(1);
    check("R9 pins unaffected", {macro_sel_n, macro_strobe, macro_load, macro_pgm_n, 18'd0, macro_addr},
          {1'b0, 1'b1, 1'b1, 1'b1, 18'd0, 10'h0CC});
    bus_read(8'h04, {24'd0, pat(10'h0CC)}, "R9 capture with junk bits");

    // load low reads zero
    bus_write(8'h00, 32'h0000_0008 | (32'h0CC << 6));
    bus_read(8'h04, 32'h0, "R5 load low");

    // ignored writes
    bus_write(8'h00, 32'h0000_000C | (32'h0CC << 6));
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, {24'd0, pat(10'h0CC)}, "R7 dout write ignored");
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h00, 32'h0000_000C | (32'h0CC << 6), "R7 unmapped write ignored");
    bus_read(8'h10, 32'h0, "R7 unmapped read zero");

    // standby clears
    bus_write(8'h00, 32'h0000_0009);
    bus_read(8'h04, 32'h0, "R5 standby zero");
    bus_write(8'h00, 32'h0000_000C | (32'h0CC << 6));
    bus_read(8'h04, 32'h0, "R5 cleared after deselect");

    // strobe rise while deselected does not capture
    bus_write(8'h00, 32'h0000_000B | (32'h011 << 6));
    bus_write(8'h00, 32'h0000_000C | (32'h011 << 6));
    bus_read(8'h04, 32'h0, "R3 no capture when deselected");

    idle(4);
    check("R8 all accesses completed", 32'(sb.size()), 32'd0);
    check("R8 idle ready low at end", 32'(bus_ready), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule